// File: doc/BRIEF.md
# CAN receiver interrupt flag register

This block is the receive-side event and status register of a CAN controller, together with its interrupt enable register. Hardware pulses set the event flags: wake-up, status change, overrun and receive-buffer-full. Software clears a flag by writing 1 to its bit. The clear is refused while the cause of the flag is still present, and it also loses to a set pulse that arrives in the same cycle.

Two 2-bit fields report the error state of the receiver and of the transmitter. They follow their inputs one cycle late and cannot be written. A change in either field raises the status-change flag. While the controller is in initialization mode, the event flags are held clear and writes are refused, but the status fields keep tracking. The interrupt request combines each event flag with its own enable bit.

Top module: `can_rx_flag_reg`

## Requirements
- R1: After reset, rd_flags, rd_ien and irq are all 0.
- R2: The flag register read layout is: bit 7 wake-up, bit 6 status change, bits 5:4 receiver status, bits 3:2 transmitter status, bit 1 overrun, bit 0 receive-buffer-full. wr_sel 0 addresses the flag register and wr_sel 1 addresses the enable register.
- R3: A one-cycle pulse on wake_set, ovr_set or rxf_set sets its flag, visible after the next clock edge.
- R4: Writing 1 to a flag bit clears that flag when its condition is absent. Writing 0 leaves the flag unchanged.
- R5: A clear write is ignored while the flag's condition input (wake_busy, ovr_busy, rxf_busy) is high, and the flag stays set.
- R6: If a set pulse and a clear write reach the same flag in the same cycle, the flag ends up set.
- R7: Bits 5:4 and 3:2 show rx_stat and tx_stat as registered one cycle earlier. Writes to these bits are ignored.
- R8: The status-change flag is set whenever either status field takes a new value.
- R9: While init_req and init_ack are both high, bits 7, 6, 1 and 0 are held at 0 and set pulses have no effect. The status fields keep tracking, and a change seen during this time leaves no status-change flag behind.
- R10: Writes to the flag register take effect only when init_req and init_ack are both low. When exactly one of them is high, writes are ignored but set pulses still set flags.
- R11: The enable register stores bits 7, 6, 1 and 0 and reads 0 elsewhere. irq is high exactly when some flag is set and its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the flag register, 1 selects the enable register |
| wr_data | input | 8 | Write data |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| wake_set | input | 1 | Wake-up event pulse |
| wake_busy | input | 1 | Wake-up condition still present |
| ovr_set | input | 1 | Overrun event pulse |
| ovr_busy | input | 1 | Overrun condition still present |
| rxf_set | input | 1 | Receive-buffer-full event pulse |
| rxf_busy | input | 1 | Receive buffer still unread |
| rx_stat | input | 2 | Receiver error state code |
| tx_stat | input | 2 | Transmitter error state code |
| rd_flags | output | 8 | Flag register contents |
| rd_ien | output | 8 | Enable register contents |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the moments when two agents act on one flag at once. One is a set pulse in the same cycle as a clear write. The other is a clear write while the cause of the flag is still asserted. The directed tasks place both events on a single falling edge, so that one rising edge sees them together. The half-entered initialization state, with only one of the two handshake signals high, is driven on purpose. Bench checks then confirm that writes are refused there while set pulses still land. A status change made during full initialization is checked after exit, to confirm it left no status-change flag behind.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int REG_W   = 8;
  localparam int FLAG_N  = 4;
  localparam int STAT_W  = 2;

  // flag index -> bit position in the readable register
  // index 0 rx-full, 1 overrun, 2 status change, 3 wake-up
  localparam int FLAG_POS [FLAG_N] = '{0, 1, 6, 7};

  localparam int POS_RXST = 4;
  localparam int POS_TXST = 2;

  localparam logic [REG_W-1:0] IEN_MASK = 8'hC3;

  typedef enum logic {
    SEL_FLAG = 1'b0,
    SEL_IEN  = 1'b1
  } crf_sel_e;
endpackage

// File: rtl/crf_rst_sync.sv
module crf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/crf_stat_track.sv
module crf_stat_track #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] stat_o,
  output logic         chg_o
);
  logic [W-1:0] stat_q;
  logic         upd;

  always_comb begin
    upd = (stat_i != stat_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat_q <= '0;
    else if (upd) stat_q <= stat_i;
  end

  assign stat_o = stat_q;
  assign chg_o  = upd;
endmodule

// File: rtl/crf_flag_cell.sv
module crf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic set_i,
  input  logic busy_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic upd;

  always_comb begin
    upd    = 1'b0;
    flag_d = flag_q;
    if (hold_i) begin
      upd    = 1'b1;
      flag_d = 1'b0;
    end else if (set_i) begin
      upd    = 1'b1;
      flag_d = 1'b1;
    end else if (clr_i && !busy_i) begin
      upd    = 1'b1;
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (upd) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/crf_ien.sv
module crf_ien
  import crf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] data_i,
  input  logic [REG_W-1:0] flags_i,
  output logic [REG_W-1:0] ien_o,
  output logic             irq_o
);
  logic [REG_W-1:0] ien_q;
  logic [REG_W-1:0] ien_d;

  always_comb begin
    ien_d = data_i & IEN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ien_q <= '0;
    else if (wr_i) ien_q <= ien_d;
  end

  assign ien_o = ien_q;
  assign irq_o = |(flags_i & ien_q & IEN_MASK);
endmodule

// File: rtl/can_rx_flag_reg.sv
module can_rx_flag_reg
  import crf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              init_req,
  input  logic              init_ack,
  input  logic              wake_set,
  input  logic              wake_busy,
  input  logic              ovr_set,
  input  logic              ovr_busy,
  input  logic              rxf_set,
  input  logic              rxf_busy,
  input  logic [STAT_W-1:0] rx_stat,
  input  logic [STAT_W-1:0] tx_stat,
  output logic [REG_W-1:0]  rd_flags,
  output logic [REG_W-1:0]  rd_ien,
  output logic              irq
);
  localparam int SW = 2 * STAT_W;

  logic              rst_q;
  logic              hold;
  logic              wr_flag;
  logic              wr_ien;
  logic [SW-1:0]     stat_q;
  logic              stat_chg;
  logic [FLAG_N-1:0] f_set;
  logic [FLAG_N-1:0] f_busy;
  logic [FLAG_N-1:0] f_q;
  logic [REG_W-1:0]  flags_w;

  crf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  always_comb begin
    hold    = init_req && init_ack;
    wr_flag = wr_en && (wr_sel == SEL_FLAG) && !init_req && !init_ack;
    wr_ien  = wr_en && (wr_sel == SEL_IEN);
    f_set   = {wake_set,  stat_chg, ovr_set,  rxf_set};
    f_busy  = {wake_busy, stat_chg, ovr_busy, rxf_busy};
  end

  crf_stat_track #(.W(SW)) u_stat (
    .clk    (clk),
    .rst_n  (rst_q),
    .stat_i ({rx_stat, tx_stat}),
    .stat_o (stat_q),
    .chg_o  (stat_chg)
  );

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    crf_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_q),
      .hold_i (hold),
      .set_i  (f_set[g]),
      .busy_i (f_busy[g]),
      .clr_i  (wr_flag && wr_data[FLAG_POS[g]]),
      .flag_o (f_q[g])
    );
  end

  always_comb begin
    flags_w = '0;
    for (int i = 0; i < FLAG_N; i++) flags_w[FLAG_POS[i]] = f_q[i];
    flags_w[POS_RXST +: STAT_W] = stat_q[STAT_W +: STAT_W];
    flags_w[POS_TXST +: STAT_W] = stat_q[0 +: STAT_W];
  end

  crf_ien u_ien (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_i    (wr_ien),
    .data_i  (wr_data),
    .flags_i (flags_w),
    .ien_o   (rd_ien),
    .irq_o   (irq)
  );

  assign rd_flags = flags_w;
endmodule

// File: rtl/crf_chk.sv
module crf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_req,
  input logic       init_ack,
  input logic       rxf_set,
  input logic       ovr_busy,
  input logic [1:0] rx_stat,
  input logic [1:0] tx_stat,
  input logic [7:0] rd_flags,
  input logic       irq
);
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // R6: a set pulse always lands, even against a clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(rxf_set) && !$past(init_req && init_ack) |-> rd_flags[0]);

  // R5: a set flag survives while its condition holds
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(ovr_busy && rd_flags[1] && !(init_req && init_ack)) |-> rd_flags[1]);

  // R9: initialization mode clears every event flag
  p_init_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(init_req && init_ack) |-> (rd_flags & 8'hC3) == 8'h00);

  // R7: status fields follow the inputs one cycle late
  p_stat_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> rd_flags[5:2] == $past({rx_stat, tx_stat}));

  // R8: a status change raises the change flag
  p_chg_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    live && ($past({rx_stat, tx_stat}) != $past(rd_flags[5:2]))
         && !$past(init_req && init_ack) |-> rd_flags[6]);

  // R11: no request without a pending event flag
  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_flags & 8'hC3) != 8'h00);
endmodule

bind can_rx_flag_reg crf_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .init_req (init_req),
  .init_ack (init_ack),
  .rxf_set  (rxf_set),
  .ovr_busy (ovr_busy),
  .rx_stat  (rx_stat),
  .tx_stat  (tx_stat),
  .rd_flags (rd_flags),
  .irq      (irq)
);

// File: tb/sim_can_rx_flag_reg.sv
`timescale 1ns/1ps
module sim_can_rx_flag_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_sel;
  logic [7:0] wr_data;
  logic       init_req, init_ack;
  logic       wake_set, wake_busy, ovr_set, ovr_busy, rxf_set, rxf_busy;
  logic [1:0] rx_stat, tx_stat;
  logic [7:0] rd_flags, rd_ien;
  logic       irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  can_rx_flag_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .init_req(init_req), .init_ack(init_ack),
    .wake_set(wake_set), .wake_busy(wake_busy),
    .ovr_set(ovr_set), .ovr_busy(ovr_busy),
    .rxf_set(rxf_set), .rxf_busy(rxf_busy),
    .rx_stat(rx_stat), .tx_stat(tx_stat),
    .rd_flags(rd_flags), .rd_ien(rd_ien), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: rxf_set = 1'b1;
      1: ovr_set = 1'b1;
      default: wake_set = 1'b1;
    endcase
    @(negedge clk); rxf_set = 1'b0; ovr_set = 1'b0; wake_set = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    init_req = 1'b0; init_ack = 1'b0;
    wake_set = 1'b0; wake_busy = 1'b0; ovr_set = 1'b0; ovr_busy = 1'b0;
    rxf_set = 1'b0; rxf_busy = 1'b0; rx_stat = 2'b00; tx_stat = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 flags", rd_flags, 8'h00);
    check("R1 ien", rd_ien, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_set_irq;
    pulse(0);
    check("R3 R2 rxf at bit0", rd_flags, 8'h01);
    wr(1'b1, 8'hFF);
    check("R11 ien mask", rd_ien, 8'hC3);
    check("R11 irq on", {7'd0, irq}, 8'h01);
    wr(1'b1, 8'h02);
    check("R11 irq masked", {7'd0, irq}, 8'h00);
    pulse(1);
    check("R3 R2 ovr at bit1", rd_flags, 8'h03);
    check("R11 irq ovr", {7'd0, irq}, 8'h01);
    pulse(2);
    check("R3 R2 wake at bit7", rd_flags, 8'h83);
  endtask

  task automatic t_clear;
    wr(1'b0, 8'h00);
    check("R4 write 0 no effect", rd_flags, 8'h83);
    rxf_busy = 1'b1;
    wr(1'b0, 8'h01);
    check("R5 clear refused while busy", rd_flags, 8'h83);
    rxf_busy = 1'b0;
    wr(1'b0, 8'h83);
    check("R4 clear all", rd_flags, 8'h00);
    check("R11 irq off", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_set_wins;
    pulse(0);
    @(negedge clk); rxf_set = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h01;
    @(negedge clk); rxf_set = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    check("R6 set beats clear", rd_flags, 8'h01);
    wr(1'b0, 8'h01);
    check("R4 clear after", rd_flags, 8'h00);
  endtask

  task automatic t_status;
    @(negedge clk); rx_stat = 2'b10;
    @(negedge clk);
    check("R7 R8 rx status change", rd_flags, 8'h60);
    wr(1'b0, 8'h7C);
    check("R7 status write ignored, R4 change cleared", rd_flags, 8'h20);
    @(negedge clk); tx_stat = 2'b11;
    @(negedge clk);
    check("R8 R2 tx status change", rd_flags, 8'h6C);
    wr(1'b0, 8'h40);
    check("R4 change cleared", rd_flags, 8'h2C);
    @(negedge clk); rx_stat = 2'b00; tx_stat = 2'b00;
    @(negedge clk);
    check("R7 R8 back to zero", rd_flags, 8'h40);
    wr(1'b0, 8'h40);
    check("R4 clean", rd_flags, 8'h00);
  endtask

  task automatic t_init;
    pulse(1); pulse(2);
    check("R3 pre-init", rd_flags, 8'h82);
    @(negedge clk); init_req = 1'b1;
    wr(1'b0, 8'h82);
    check("R10 write refused half-init", rd_flags, 8'h82);
    pulse(0);
    check("R10 set works half-init", rd_flags, 8'h83);
    @(negedge clk); init_ack = 1'b1;
    @(negedge clk);
    check("R9 held clear", rd_flags, 8'h00);
    pulse(1);
    check("R9 set ignored in init", rd_flags, 8'h00);
    @(negedge clk); rx_stat = 2'b01;
    @(negedge clk);
    check("R9 status tracks in init", rd_flags, 8'h10);
    @(negedge clk); init_req = 1'b0; init_ack = 1'b0;
    @(negedge clk);
    check("R9 no change flag after exit", rd_flags, 8'h10);
    pulse(0);
    wr(1'b0, 8'h01);
    check("R10 writable after exit", rd_flags, 8'h10);
    @(negedge clk); rx_stat = 2'b00;
    @(negedge clk);
    wr(1'b0, 8'h40);
    check("R7 final", rd_flags, 8'h00);
  endtask

  initial begin
    t_reset();
    t_set_irq();
    t_clear();
    t_set_wins();
    t_status();
    t_init();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule